// File: doc/BRIEF.md
# ADC Single-Conversion Timing Sequencer

This block times one single-mode conversion of a successive-approximation A/D converter. It works entirely in system clock states. It does not model the analog comparator, the DAC or the bit-decision logic. It only decides when the converter is busy, when the sample-and-hold switch is closed, and when the approximation phase runs. At the end it reports completion with a one-clock pulse.

A conversion can be requested in two ways. Software can raise a start strobe. An external trigger pin can also request one: its falling edge counts only when both bits of a two-bit enable field are set. The pin is synchronised through a two-stage flip-flop chain before its edge is detected. Both request paths set the same busy flag, and they produce identical conversions.

A clock-select input chooses one of two timing sets. The slow set uses a 20-state start delay, a 129-state sample window and 520 states in total. The fast set uses a 12-state delay, a 65-state window and 262 states in total. The select value is captured when a conversion is accepted. The block has no data path, so all of its pins are plain control and status signals and no valid/ready handshake is needed.

Top module: `adc_seq_timer`

## Requirements
- R1: After reset, busy, sample-hold enable, conversion strobe and done are all 0.
- R2: When busy is 0, a 1 on sw_start at a rising clock edge makes busy 1 from that edge onward.
- R3: After busy rises, a start-delay phase follows with both sh_en and conv_phase at 0. It lasts 20 cycles when the captured select is 0 and 12 cycles when it is 1. Both values lie inside the allowed windows of 17..28 and 10..17 states.
- R4: sh_en is high for one unbroken run directly after the delay: 129 cycles for select 0 and 65 cycles for select 1. sh_en and conv_phase are never high together.
- R5: conv_phase is high from the end of the sample window until busy falls. Busy stays high for 520 cycles in total with select 0 and 262 cycles with select 1.
- R6: done is high for exactly one cycle, the first cycle after busy falls, and at no other time.
- R7: With trig_en == 2'b11, a high-to-low change on trig_n_pin that is first seen at rising edge e1 makes busy 1 after edge e1+2.
- R8: When trig_en is 2'b00, 2'b01 or 2'b10, trigger edges start nothing.
- R9: Start requests from either source that arrive while busy is 1 are dropped. They neither restart nor lengthen the running conversion.
- R10: clk_sel is captured when a conversion is accepted. A change to clk_sel during a conversion affects only later conversions.
- R11: A software start and a trigger accepted at the same edge give a single conversion. A request present in the done cycle starts the next conversion at once.
- R12: A low-to-high change on trig_n_pin starts nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; one period is one state |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_start | input | 1 | Software start request, sampled at each rising edge |
| trig_en | input | 2 | Trigger enable field; the trigger is honoured only at 2'b11 |
| trig_n_pin | input | 1 | Asynchronous external trigger, active on its falling edge |
| clk_sel | input | 1 | Timing set: 0 slow, 1 fast |
| busy | output | 1 | Start flag; high for the whole conversion |
| sh_en | output | 1 | Sample-and-hold enable during the sampling window |
| conv_phase | output | 1 | High during the approximation phase |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two kinds of event can fall in the same cycle. The first is a software start together with a synchronised trigger edge. The bench drives the pin low two edges ahead, so that its detected edge reaches the sequencer at the same clock as a software strobe; exactly one conversion of the expected length must then appear. The second is a start request together with the done cycle. The bench holds sw_start high across the end of a conversion and checks that busy is 0 while done is high and 1 again on the following cycle. A scoreboard holds one expected entry per conversion, so any extra conversion in either case is reported.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_DELAY  = 2'd1,
    PH_SAMPLE = 2'd2,
    PH_CONV   = 2'd3
  } phase_e;

  localparam logic [1:0] TRIG_ARMED = 2'b11;
endpackage

// File: rtl/adc_trig_detect.sv
module adc_trig_detect #(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_n,
  input  logic [1:0] enable,
  output logic       fall
);
  import adc_seq_pkg::*;

  logic [STAGES-1:0] chain;
  logic              last_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b1;
          else        chain[0] <= pin_n;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= 1'b1;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b1;
    else        last_q <= chain[STAGES-1];
  end

  assign fall = (enable == TRIG_ARMED) && last_q && !chain[STAGES-1];
endmodule

// File: rtl/adc_phase_timer.sv
module adc_phase_timer #(
  parameter int DLY_SLOW = 20,
  parameter int SMP_SLOW = 129,
  parameter int TOT_SLOW = 520,
  parameter int DLY_FAST = 12,
  parameter int SMP_FAST = 65,
  parameter int TOT_FAST = 262,
  parameter int CW       = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  input  logic sel,
  output logic busy,
  output logic sh_en,
  output logic conv_phase,
  output logic done,
  output logic sel_q
);
  import adc_seq_pkg::*;

  localparam int CNV_SLOW = TOT_SLOW - DLY_SLOW - SMP_SLOW;
  localparam int CNV_FAST = TOT_FAST - DLY_FAST - SMP_FAST;

  phase_e        ph;
  logic [CW-1:0] cnt;

  function automatic logic [CW-1:0] load_val(input phase_e p, input logic fast);
    int len;
    case (p)
      PH_DELAY:  len = fast ? DLY_FAST : DLY_SLOW;
      PH_SAMPLE: len = fast ? SMP_FAST : SMP_SLOW;
      default:   len = fast ? CNV_FAST : CNV_SLOW;
    endcase
    return CW'(len - 1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph    <= PH_IDLE;
      cnt   <= '0;
      sel_q <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (ph)
        PH_IDLE: begin
          if (start_req) begin
            sel_q <= sel;
            ph    <= PH_DELAY;
            cnt   <= load_val(PH_DELAY, sel);
          end
        end
        PH_DELAY: begin
          if (cnt == '0) begin
            ph  <= PH_SAMPLE;
            cnt <= load_val(PH_SAMPLE, sel_q);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_SAMPLE: begin
          if (cnt == '0) begin
            ph  <= PH_CONV;
            cnt <= load_val(PH_CONV, sel_q);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          if (cnt == '0) begin
            ph   <= PH_IDLE;
            done <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
      endcase
    end
  end

  assign busy       = (ph != PH_IDLE);
  assign sh_en      = (ph == PH_SAMPLE);
  assign conv_phase = (ph == PH_CONV);
endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
  parameter int SYNC_STAGES = 2,
  parameter int DLY_SLOW    = 20,
  parameter int SMP_SLOW    = 129,
  parameter int TOT_SLOW    = 520,
  parameter int DLY_FAST    = 12,
  parameter int SMP_FAST    = 65,
  parameter int TOT_FAST    = 262
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sw_start,
  input  logic [1:0] trig_en,
  input  logic       trig_n_pin,
  input  logic       clk_sel,
  output logic       busy,
  output logic       sh_en,
  output logic       conv_phase,
  output logic       done
);
  localparam int TOT_MAX = (TOT_SLOW > TOT_FAST) ? TOT_SLOW : TOT_FAST;
  localparam int CW      = $clog2(TOT_MAX) + 1;

  logic trig_fall;
  logic start_req;
  logic sel_q;

  adc_trig_detect #(.STAGES(SYNC_STAGES)) u_trig (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_n  (trig_n_pin),
    .enable (trig_en),
    .fall   (trig_fall)
  );

  assign start_req = sw_start | trig_fall;

  adc_phase_timer #(
    .DLY_SLOW (DLY_SLOW), .SMP_SLOW (SMP_SLOW), .TOT_SLOW (TOT_SLOW),
    .DLY_FAST (DLY_FAST), .SMP_FAST (SMP_FAST), .TOT_FAST (TOT_FAST),
    .CW       (CW)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_req  (start_req),
    .sel        (clk_sel),
    .busy       (busy),
    .sh_en      (sh_en),
    .conv_phase (conv_phase),
    .done       (done),
    .sel_q      (sel_q)
  );
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic sw_start,
  input logic busy,
  input logic sh_en,
  input logic conv_phase,
  input logic done,
  input logic sel_q
);
  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && sw_start) |=> busy); // R2

  AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(sh_en && conv_phase)); // R4

  AST_SAMPLE_AFTER_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sh_en) |-> ($past(busy) && !$past(conv_phase))); // R4

  AST_CONV_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(conv_phase) |-> (!busy && done)); // R5

  AST_DONE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R6

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R6

  AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(sel_q)); // R10
endmodule

bind adc_seq_timer adc_seq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sw_start   (sw_start),
  .busy       (busy),
  .sh_en      (sh_en),
  .conv_phase (conv_phase),
  .done       (done),
  .sel_q      (sel_q)
);

// File: tb/adc_seq_timer_tb.sv
`timescale 1ns/1ps
module adc_seq_timer_tb_top;
  localparam int D0 = 20, S0 = 129, T0 = 520;
  localparam int D1 = 12, S1 = 65,  T1 = 262;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sw_start = 1'b0;
  logic [1:0] trig_en = 2'b00;
  logic       trig_n_pin = 1'b1;
  logic       clk_sel = 1'b0;
  logic       busy, sh_en, conv_phase, done;

  int checks = 0;
  int errors = 0;
  int exp_q[$];

  always #4 clk = ~clk;

  adc_seq_timer dut_i (
    .clk(clk), .rst_n(rst_n), .sw_start(sw_start), .trig_en(trig_en),
    .trig_n_pin(trig_n_pin), .clk_sel(clk_sel), .busy(busy),
    .sh_en(sh_en), .conv_phase(conv_phase), .done(done)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Monitor: measures each conversion and compares with the scoreboard entry
  logic prev_busy = 1'b0;
  int   nd = 0, ns = 0, nc = 0, cur_sel = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy && !prev_busy) begin
        if (exp_q.size() == 0) begin
          check(0, "R9/R11 unexpected conversion", 1, 0);
          cur_sel = 0;
        end else begin
          cur_sel = exp_q.pop_front();
        end
        nd = 0; ns = 0; nc = 0;
      end
      if (busy) begin
        if (sh_en) ns++;
        else if (conv_phase) nc++;
        else nd++;
      end
      if (!busy && prev_busy) begin
        check(nd == (cur_sel ? D1 : D0), "R3 delay length", nd, cur_sel ? D1 : D0);
        check(ns == (cur_sel ? S1 : S0), "R4 sample length", ns, cur_sel ? S1 : S0);
        check(nd + ns + nc == (cur_sel ? T1 : T0), "R5 total length R10",
              nd + ns + nc, cur_sel ? T1 : T0);
        check(done == 1'b1, "R6 done at end", done, 1);
      end else if (done) begin
        check(0, "R6 stray done", 1, 0);
      end
      prev_busy = busy;
    end
  end

  task automatic sw_conv(input logic s);
    exp_q.push_back(int'(s));
    @(negedge clk);
    sw_start = 1'b1;
    clk_sel  = s;
    @(negedge clk);
    sw_start = 1'b0;
    check(busy == 1'b1, "R2 busy after start", busy, 1);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic idle_for(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(busy == 1'b0, tag, busy, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 0 && sh_en == 0 && conv_phase == 0 && done == 0, "R1 reset state",
          {busy, sh_en, conv_phase, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2..R6 software starts, both timing sets
    sw_conv(1'b0); wait_idle();
    sw_conv(1'b1); wait_idle();

    // R7 trigger latency, then R12 rising edge
    exp_q.push_back(0);
    clk_sel = 1'b0;
    trig_en = 2'b11;
    @(negedge clk); trig_n_pin = 1'b0;
    @(negedge clk); check(busy == 1'b0, "R7 no start yet", busy, 0);
    @(negedge clk); check(busy == 1'b0, "R7 no start yet", busy, 0);
    @(negedge clk); check(busy == 1'b1, "R7 trigger started", busy, 1);
    wait_idle();
    trig_n_pin = 1'b1;
    idle_for(6, "R12 rising edge ignored");

    // R8 partial enable fields
    for (int e = 0; e < 3; e++) begin
      trig_en = 2'(e);
      @(negedge clk); trig_n_pin = 1'b0;
      idle_for(6, "R8 trigger disabled");
      trig_n_pin = 1'b1;
      idle_for(3, "R8 trigger disabled");
    end

    // R9 requests during busy are dropped
    sw_conv(1'b0);
    repeat (30) @(negedge clk);
    sw_start = 1'b1; @(negedge clk); sw_start = 1'b0;
    trig_en = 2'b11; trig_n_pin = 1'b0;
    repeat (100) @(negedge clk);
    trig_n_pin = 1'b1;
    repeat (250) @(negedge clk);
    sw_start = 1'b1; @(negedge clk); sw_start = 1'b0;
    wait_idle();
    idle_for(5, "R9 no restart");

    // R10 select change mid conversion
    sw_conv(1'b1);
    repeat (5) @(negedge clk);
    clk_sel = 1'b0;
    wait_idle();

    // R11 coincident software start and trigger edge
    exp_q.push_back(0);
    clk_sel = 1'b0;
    trig_en = 2'b11;
    @(negedge clk); trig_n_pin = 1'b0;
    @(negedge clk);
    @(negedge clk); sw_start = 1'b1;
    @(negedge clk); sw_start = 1'b0;
    check(busy == 1'b1, "R11 coincident start", busy, 1);
    wait_idle();
    trig_n_pin = 1'b1;
    idle_for(5, "R11 single conversion");

    // R11 request held through the done cycle
    exp_q.push_back(1);
    exp_q.push_back(1);
    @(negedge clk); sw_start = 1'b1; clk_sel = 1'b1;
    @(negedge clk);
    while (!done) @(negedge clk);
    check(busy == 1'b0, "R11 idle in done cycle", busy, 0);
    @(negedge clk);
    sw_start = 1'b0;
    check(busy == 1'b1, "R11 back-to-back start", busy, 1);
    wait_idle();
    idle_for(3, "R11 no third conversion");

    check(exp_q.size() == 0, "R9 scoreboard drained", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule